// File: doc/BRIEF.md
# Multi-Mode Bit-Vector Shifter

This block shifts a data word by a variable amount in one of five directions and fill policies, chosen by a 3-bit mode code. Two left shifts differ only in their fill value. The numeric left shift brings in zeros, so the result equals the input times a power of two, truncated to the word width. The mirror left shift copies the input's original least significant bit into every vacated low position. It is the exact mirror of the arithmetic right shift, which copies the original most significant bit downward. The logical left and right shifts bring in zeros.

The word width is a parameter. The shift-amount port is wide enough to hold any value from zero to the width. A shift amount at or beyond the width fills the whole word with the mode's fill value. A build-time parameter chooses between two output variants. One is a purely combinational result. The other is an output register with a valid strobe, which adds one cycle of latency and holds the last captured result while no new input is presented.

Top module: `bitvec_shifter`

## Requirements
- R1: Mode code 3'b000 (logical left) moves bit i of the input to bit i+n of the result and sets the n lowest result bits to 0.
- R2: Mode code 3'b001 (logical right) moves bit i of the input to bit i-n and sets the n highest result bits to 0.
- R3: Mode code 3'b010 (mirror left) shifts left as in R1 but sets every vacated low bit to the original input bit 0; for a 4-bit input 4'b0001 shifted by 2 the result is 4'b0111.
- R4: Mode code 3'b011 (arithmetic right) shifts right as in R2 but sets every vacated high bit to the original input MSB.
- R5: Mode code 3'b100 (numeric left) zero-fills, so the result is input times 2^n modulo 2^WIDTH; for 4'b0001 shifted by 2 the result is 4'b0100.
- R6: A shift amount greater than or equal to WIDTH gives a result with every bit equal to the mode's fill value: 0 for codes 000, 001 and 100, input bit 0 for 010, input MSB for 011.
- R7: A shift amount of zero returns the input unchanged in every mode.
- R8: Mode codes 3'b101, 3'b110 and 3'b111 return the input unchanged, whatever the shift amount.
- R9: With REGISTER_OUT=1, an input presented with in_valid high appears on result, with out_valid high, one clock later. While in_valid is low, out_valid goes low one clock later and result holds its value. With REGISTER_OUT=0, result follows the inputs in the same cycle and out_valid equals in_valid.
- R10: With REGISTER_OUT=1, a clock edge with rst_n low clears result and out_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks data_in, shamt and mode as a new operation |
| data_in | input | WIDTH | Word to be shifted |
| shamt | input | $clog2(WIDTH+1) | Shift distance in bit positions |
| mode | input | 3 | Shift mode code (see R1 to R8) |
| result | output | WIDTH | Shifted word |
| out_valid | output | 1 | Marks result as belonging to a valid operation |

## Verification
A wrong fill-bit selection shows up only on the vacated bit positions, and only when the chosen fill source differs from zero. A mirror-left fault is therefore invisible unless the input LSB is 1, and an arithmetic-right fault unless the MSB is 1. The sweep covers every data value, every amount and every code, so any such fault appears on result in the cycle after the operation is presented. A fault in the barrel stages or in the saturation compare corrupts specific amounts, including those between WIDTH and the port maximum. A fault in the output register shows as a missing hold or a missing one-cycle delay of out_valid.

// File: rtl/shifter_pkg.sv
// Package: shifter_pkg
// Shared mode codes and the decoded control word for the bit-vector shifter.
// Assumes a 3-bit mode field; codes not listed here mean pass-through.
package shifter_pkg;

    typedef enum logic [2:0] {
        SH_LOG_LEFT   = 3'b000,
        SH_LOG_RIGHT  = 3'b001,
        SH_MIRROR_LFT = 3'b010,
        SH_ARITH_RGT  = 3'b011,
        SH_NUM_LEFT   = 3'b100
    } shift_mode_e;

    typedef struct packed {
        logic go_right;   // shift toward bit 0 instead of toward the MSB
        logic fill;       // value placed in vacated positions
        logic pass;       // return the input untouched
    } shift_ctl_t;

endpackage

// File: rtl/shift_mode_decode.sv
// Module: shift_mode_decode
// Turns the 3-bit mode code into direction, fill value and pass-through
// controls. Assumes the fill sources (input LSB and MSB) are the original,
// unshifted bits of the data word.
module shift_mode_decode
    import shifter_pkg::*;
(
    input  logic       data_lsb,
    input  logic       data_msb,
    input  logic [2:0] mode,
    output shift_ctl_t ctl
);

    // Map each mode code to its control word.
    always_comb begin
        ctl = '{go_right: 1'b0, fill: 1'b0, pass: 1'b0};
        case (mode)
            SH_LOG_LEFT:   ctl = '{go_right: 1'b0, fill: 1'b0,     pass: 1'b0};
            SH_LOG_RIGHT:  ctl = '{go_right: 1'b1, fill: 1'b0,     pass: 1'b0};
            SH_MIRROR_LFT: ctl = '{go_right: 1'b0, fill: data_lsb, pass: 1'b0};
            SH_ARITH_RGT:  ctl = '{go_right: 1'b1, fill: data_msb, pass: 1'b0};
            SH_NUM_LEFT:   ctl = '{go_right: 1'b0, fill: 1'b0,     pass: 1'b0};
            default:       ctl = '{go_right: 1'b0, fill: 1'b0,     pass: 1'b1};
        endcase
    end

endmodule

// File: rtl/shift_left_core.sv
// Module: shift_left_core
// Logarithmic left barrel shifter with a programmable fill bit. Right shifts
// are obtained by the caller reversing bit order around this core.
// Assumes WIDTH >= 2 and AMT_W wide enough to hold WIDTH; any amount at or
// above WIDTH saturates to an all-fill word.
module shift_left_core #(
    parameter int WIDTH = 8,
    parameter int AMT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] data,
    input  logic [AMT_W-1:0] amt,
    input  logic             fill,
    output logic [WIDTH-1:0] shifted
);

    localparam int              STAGES = $clog2(WIDTH);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

    logic [WIDTH-1:0] stage [STAGES+1];
    logic             saturate;

    assign stage[0] = data;

    // One stage per amount bit: shift by 2^k when bit k is set.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stage[k+1] = amt[k] ? {stage[k][WIDTH-1-SH:0], {SH{fill}}}
                                   : stage[k];
    end

    // Detect amounts that push every original bit out of the word.
    assign saturate = (amt >= W_AMT);

    // Select the all-fill word on saturation, else the staged result.
    always_comb begin
        shifted = saturate ? {WIDTH{fill}} : stage[STAGES];
    end

endmodule

// File: rtl/shift_out_stage.sv
// Module: shift_out_stage
// Optional output register. With REGISTER_OUT=1 the result is captured when
// in_valid is high and held otherwise, and the valid strobe is delayed one
// cycle; reset is synchronous and active-low. With REGISTER_OUT=0 both pass
// straight through.
module shift_out_stage #(
    parameter int WIDTH        = 8,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             q_valid
);

    if (REGISTER_OUT) begin : g_reg
        // Capture result on valid input and delay the strobe by one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q       <= '0;
                q_valid <= 1'b0;
            end else begin
                q_valid <= in_valid;
                if (in_valid) begin
                    q <= d;
                end
            end
        end
    end else begin : g_comb
        logic unused_clk;
        // Bypass: no storage, clock and reset are unused.
        always_comb begin
            q          = d;
            q_valid    = in_valid;
            unused_clk = clk ^ rst_n;
        end
    end

endmodule

// File: rtl/bitvec_shifter.sv
// Module: bitvec_shifter (top)
// Multi-mode shifter: logical left/right, mirror left (LSB fill), arithmetic
// right (MSB fill), numeric left (zero fill) and pass-through for unused
// codes. Right shifts reuse the left core by reversing bit order on the way
// in and out. Assumes WIDTH >= 2.
module bitvec_shifter #(
    parameter int WIDTH        = 8,
    parameter bit REGISTER_OUT = 1'b1,
    localparam int AMT_W       = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] shamt,
    input  logic [2:0]       mode,
    output logic [WIDTH-1:0] result,
    output logic             out_valid
);

    import shifter_pkg::*;

    shift_ctl_t       ctl;
    logic [WIDTH-1:0] data_rev;
    logic [WIDTH-1:0] core_in;
    logic [WIDTH-1:0] core_out;
    logic [WIDTH-1:0] core_out_rev;
    logic [WIDTH-1:0] shifted;

    shift_mode_decode u_decode (
        .data_lsb (data_in[0]),
        .data_msb (data_in[WIDTH-1]),
        .mode     (mode),
        .ctl      (ctl)
    );

    // Bit reversal of the input and of the core output.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign data_rev[i]     = data_in[WIDTH-1-i];
        assign core_out_rev[i] = core_out[WIDTH-1-i];
    end

    // Present the word to the core in left-shift orientation.
    always_comb begin
        core_in = ctl.go_right ? data_rev : data_in;
    end

    shift_left_core #(
        .WIDTH (WIDTH),
        .AMT_W (AMT_W)
    ) u_core (
        .data    (core_in),
        .amt     (shamt),
        .fill    (ctl.fill),
        .shifted (core_out)
    );

    // Restore orientation and apply pass-through for unused codes.
    always_comb begin
        if (ctl.pass) begin
            shifted = data_in;
        end else if (ctl.go_right) begin
            shifted = core_out_rev;
        end else begin
            shifted = core_out;
        end
    end

    shift_out_stage #(
        .WIDTH        (WIDTH),
        .REGISTER_OUT (REGISTER_OUT)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d        (shifted),
        .q        (result),
        .q_valid  (out_valid)
    );

endmodule

// File: rtl/shifter_checker.sv
// Module: shifter_checker
// Port-level properties for bitvec_shifter, bound into every instance.
// Assumes the same parameters as the bound instance.
module shifter_checker #(
    parameter int WIDTH        = 8,
    parameter int AMT_W        = 4,
    parameter bit REGISTER_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] data_in,
    input logic [AMT_W-1:0] shamt,
    input logic [2:0]       mode,
    input logic [WIDTH-1:0] result,
    input logic             out_valid
);

    if (REGISTER_OUT) begin : g_reg_props
        p_log_left_lsb_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 3'b000 && shamt != '0) |=> (result[0] == 1'b0));
        p_log_right_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 3'b001 && shamt != '0) |=> (result[WIDTH-1] == 1'b0));
        p_mirror_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 3'b010 && shamt != '0) |=> (result[0] == $past(data_in[0])));
        p_arith_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 3'b011) |=> (result[WIDTH-1] == $past(data_in[WIDTH-1])));
        p_num_left_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 3'b100 && shamt != '0) |=> (result[0] == 1'b0));
        p_zero_amt_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && shamt == '0) |=> (result == $past(data_in)));
        p_unused_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode > 3'b100) |=> (result == $past(data_in)));
        p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(result)));
    end else begin : g_comb_props
        p_log_left_lsb_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 3'b000 && shamt != '0) |-> (result[0] == 1'b0));
        p_log_right_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 3'b001 && shamt != '0) |-> (result[WIDTH-1] == 1'b0));
        p_mirror_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 3'b010 && shamt != '0) |-> (result[0] == data_in[0]));
        p_arith_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 3'b011) |-> (result[WIDTH-1] == data_in[WIDTH-1]));
        p_num_left_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 3'b100 && shamt != '0) |-> (result[0] == 1'b0));
        p_zero_amt_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (shamt == '0) |-> (result == data_in));
        p_unused_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode > 3'b100) |-> (result == data_in));
        p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
    end

endmodule

bind bitvec_shifter shifter_checker #(
    .WIDTH        (WIDTH),
    .AMT_W        (AMT_W),
    .REGISTER_OUT (REGISTER_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .data_in   (data_in),
    .shamt     (shamt),
    .mode      (mode),
    .result    (result),
    .out_valid (out_valid)
);

// File: tb/bitvec_shifter_tb.sv
module bitvec_shifter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TW         = 4;
    localparam int AW         = $clog2(TW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [TW-1:0] data_in = '0;
    logic [AW-1:0] shamt = '0;
    logic [2:0]    mode = '0;
    logic [TW-1:0] res_reg, res_comb;
    logic          ov_reg, ov_comb;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitvec_shifter #(.WIDTH(TW), .REGISTER_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_in(data_in),
        .shamt(shamt), .mode(mode), .result(res_reg), .out_valid(ov_reg));

    bitvec_shifter #(.WIDTH(TW), .REGISTER_OUT(1'b0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_in(data_in),
        .shamt(shamt), .mode(mode), .result(res_comb), .out_valid(ov_comb));

    // Reference computed bit by bit from the requirement text.
    function automatic logic [TW-1:0] model(logic [TW-1:0] d, int amt, int m);
        logic [TW-1:0] r;
        for (int i = 0; i < TW; i++) begin
            int src;
            case (m)
                0, 4: begin src = i - amt; r[i] = (src >= 0) ? d[src] : 1'b0; end
                2:    begin src = i - amt; r[i] = (src >= 0) ? d[src] : d[0]; end
                1:    begin src = i + amt; r[i] = (src < TW) ? d[src] : 1'b0; end
                3:    begin src = i + amt; r[i] = (src < TW) ? d[src] : d[TW-1]; end
                default: r[i] = d[i];
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(int amt, int m);
        string t;
        case (m)
            0: t = "R1"; 1: t = "R2"; 2: t = "R3"; 3: t = "R4"; 4: t = "R5";
            default: t = "R8";
        endcase
        if (amt == 0) t = {t, "/R7"};
        if (amt >= TW && m < 5) t = {t, "/R6"};
        return t;
    endfunction

    task automatic check(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] last;
        // R10: reset clears registered result and strobe.
        in_valid = 1'b1;
        data_in  = 4'hF;
        repeat (3) @(negedge clk);
        check("R10 result", res_reg, '0);
        check("R10 out_valid", {3'b0, ov_reg}, 4'b0);
        rst_n = 1'b1;

        // Spot checks of the worked example (R3, R5).
        @(negedge clk);
        data_in = 4'b0001; shamt = 3'd2; mode = 3'b010;
        @(negedge clk);
        check("R3 example", res_reg, 4'b0111);
        mode = 3'b100;
        @(negedge clk);
        check("R5 example", res_reg, 4'b0100);

        // Exhaustive sweep: every data, amount and code.
        last = '0;
        for (int d = 0; d < 16; d++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                for (int m = 0; m < 8; m++) begin
                    logic [TW-1:0] exp;
                    data_in = TW'(d);
                    shamt   = AW'(a);
                    mode    = 3'(m);
                    exp     = model(TW'(d), a, m);
                    @(negedge clk);
                    check({tag_of(a, m), " comb R9"}, res_comb, exp);
                    check({tag_of(a, m), " reg R9"}, res_reg, exp);
                    if (!ov_reg || !ov_comb) begin
                        check("R9 out_valid", {2'b0, ov_reg, ov_comb}, 4'b0011);
                    end
                    last = exp;
                end
            end
        end

        // R9: with in_valid low the register holds and the strobe drops.
        in_valid = 1'b0;
        data_in  = 4'b1010;
        shamt    = 3'd1;
        mode     = 3'b000;
        @(negedge clk);
        check("R9 hold", res_reg, last);
        check("R9 valid low", {2'b0, ov_reg, ov_comb}, 4'b0000);
        check("R9 comb follows", res_comb, 4'b0100);
        @(negedge clk);
        check("R9 hold second cycle", res_reg, last);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule